// File: doc/BRIEF.md
# Barrel Shifter with Shift Carry-Out

This block shifts a data word left or right by an amount taken either from a full-width register value or from a short immediate field. It also returns the carry flag that such a shift produces. It supports three shift kinds: logical left, logical right and arithmetic right.

In register mode only the low byte of the amount word is used. The block does not wrap large amounts. Every amount from the data width up to 255 gives a defined result and a defined carry. In immediate mode the short field is read the way a compact instruction encoding reads it: an encoded zero on either right shift stands for a full-width shift.

A valid strobe captures each operation. The result, the carry and a valid flag appear on registered outputs one clock later.

Top module: `barrel_shift_carry`

## Requirements
- R1: In register mode (imm_mode=0) the shift amount is amount_reg[7:0]; bits [31:8] have no effect, so an amount of 256 acts as a zero shift.
- R2: An effective amount of zero gives result = operand and carry_out = carry_in for every shift kind.
- R3: For an amount n from 1 to 31, the result is the operand shifted by n, and carry_out is the last bit shifted out. That bit is operand[32-n] for a left shift and operand[n-1] for a right shift. Vacated bits are 0, except on arithmetic right, where they are copies of operand[31].
- R4: A logical left shift by exactly 32 gives result 0 and carry_out = operand[0].
- R5: A logical right shift by exactly 32 gives result 0 and carry_out = operand[31].
- R6: A logical left or logical right shift by 33 to 255 gives result 0 and carry_out 0.
- R7: An arithmetic right shift by 32 to 255 gives every result bit equal to operand[31], and carry_out = operand[31].
- R8: In immediate mode (imm_mode=1) the amount is imm_amount. An encoded 0 means a shift of 32 for logical right and arithmetic right, and a zero shift for logical left.
- R9: shift_kind encodes 2'b00 as logical left, 2'b01 as logical right and 2'b10 as arithmetic right. 2'b11 passes the operand through with carry_out = carry_in.
- R10: The outputs update on a rising edge where in_valid is 1, and out_valid is 1 in the following cycle. On an edge where in_valid is 0, result and carry_out keep their values and out_valid is 0.
- R11: A synchronous active-high rst clears out_valid, result and carry_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for an operation |
| operand | input | 32 | Data word to shift |
| amount_reg | input | 32 | Register-sourced shift amount; only bits [7:0] are used |
| shift_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 pass |
| carry_in | input | 1 | Incoming carry flag |
| imm_mode | input | 1 | 1 selects imm_amount as the shift amount |
| imm_amount | input | 5 | Immediate shift amount |
| out_valid | output | 1 | A result was captured on the last edge |
| result | output | 32 | Registered shifted word |
| carry_out | output | 1 | Registered shift carry |

## Verification
The properties assume that every input is stable and known at each rising edge and that rst is high at the first edge. Without that reset, the hold and pass-through checks would compare against undefined history. The bench changes inputs only on falling edges and holds reset high for several cycles at start-up. It also raises reset mid-run only between operations. The amounts it drives deliberately fill the high byte and bits [31:8] with arbitrary values, so that the properties that mask to the low byte see real stimulus rather than clean small numbers.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_RSV = 2'b11
    } shift_kind_e;

    // Classification of the effective shift amount against the data width.
    typedef enum logic [1:0] {
        AC_ZERO   = 2'b00,
        AC_RANGE  = 2'b01,
        AC_FULL   = 2'b10,
        AC_BEYOND = 2'b11
    } amt_class_e;

    function automatic logic kind_is_right(input logic [1:0] kind);
        return (kind == SK_LSR) || (kind == SK_ASR);
    endfunction

endpackage

// File: rtl/shf_amount_sel.sv
module shf_amount_sel
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int USED_W = 8,
    parameter int IMM_W  = 5,
    parameter int EFF_W  = 8,
    parameter int STAGES = 5
) (
    input  logic [USED_W-1:0] reg_amt,
    input  logic              imm_mode,
    input  logic [IMM_W-1:0]  imm_amt,
    input  logic [1:0]        kind,
    output logic [STAGES-1:0] amt_low,
    output amt_class_e        amt_class
);

    localparam logic [EFF_W-1:0] FULL_AMT = EFF_W'(DATA_W);

    logic [EFF_W-1:0] eff_amt;

    always_comb begin
        if (imm_mode) begin
            if ((imm_amt == '0) && kind_is_right(kind)) begin
                eff_amt = FULL_AMT;
            end else begin
                eff_amt = EFF_W'(imm_amt);
            end
        end else begin
            eff_amt = EFF_W'(reg_amt);
        end
    end

    always_comb begin
        if (eff_amt == '0) begin
            amt_class = AC_ZERO;
        end else if (eff_amt == FULL_AMT) begin
            amt_class = AC_FULL;
        end else if (eff_amt > FULL_AMT) begin
            amt_class = AC_BEYOND;
        end else begin
            amt_class = AC_RANGE;
        end
    end

    assign amt_low = eff_amt[STAGES-1:0];

endmodule

// File: rtl/shf_log_stages.sv
module shf_log_stages
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STAGES = 5
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [1:0]        kind,
    input  logic [STAGES-1:0] amt_low,
    output logic [DATA_W-1:0] shifted,
    output logic [DATA_W-1:0] norm
);

    // Left shifts run through the same right-shifting network on a
    // bit-reversed word; the output is reversed back afterwards.
    logic              is_left;
    logic              fill;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_out;
    logic [DATA_W-1:0] lvl [0:STAGES];

    assign is_left = (kind == SK_LSL);
    assign fill    = (kind == SK_ASR) & operand[DATA_W-1];

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev_in
        assign rev_in[i] = operand[DATA_W-1-i];
    end

    assign norm   = is_left ? rev_in : operand;
    assign lvl[0] = norm;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign lvl[s+1] = amt_low[s] ? {{SH{fill}}, lvl[s][DATA_W-1:SH]} : lvl[s];
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev_out
        assign rev_out[i] = lvl[STAGES][DATA_W-1-i];
    end

    assign shifted = is_left ? rev_out : lvl[STAGES];

endmodule

// File: rtl/shf_carry_pick.sv
module shf_carry_pick
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STAGES = 5
) (
    input  logic [DATA_W-1:0] norm,
    input  logic              sign_bit,
    input  logic [1:0]        kind,
    input  logic [STAGES-1:0] amt_low,
    input  amt_class_e        amt_class,
    input  logic              carry_in,
    output logic              carry
);

    // In the normalised word the last bit shifted out of an n-bit shift
    // always sits at index n-1, whatever the direction.
    always_comb begin
        carry = carry_in;
        if (kind != SK_RSV) begin
            unique case (amt_class)
                AC_ZERO:   carry = carry_in;
                AC_RANGE:  carry = norm[amt_low - 1'b1];
                AC_FULL:   carry = norm[DATA_W-1];
                AC_BEYOND: carry = (kind == SK_ASR) ? sign_bit : 1'b0;
                default:   carry = carry_in;
            endcase
        end
    end

endmodule

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 32,
    parameter int USED_W = 8,
    parameter int IMM_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  amount_reg,
    input  logic [1:0]        shift_kind,
    input  logic              carry_in,
    input  logic              imm_mode,
    input  logic [IMM_W-1:0]  imm_amount,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);

    localparam int STAGES = $clog2(DATA_W);
    localparam int EFF_W  = (USED_W > STAGES) ? USED_W : STAGES + 1;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              carry;
    } out_state_t;

    out_state_t        state_d;
    out_state_t        state_q;
    logic [STAGES-1:0] amt_low;
    amt_class_e        amt_class;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] norm;
    logic              carry_sel;

    shf_amount_sel #(
        .DATA_W (DATA_W),
        .USED_W (USED_W),
        .IMM_W  (IMM_W),
        .EFF_W  (EFF_W),
        .STAGES (STAGES)
    ) u_amt (
        .reg_amt   (amount_reg[USED_W-1:0]),
        .imm_mode  (imm_mode),
        .imm_amt   (imm_amount),
        .kind      (shift_kind),
        .amt_low   (amt_low),
        .amt_class (amt_class)
    );

    shf_log_stages #(
        .DATA_W (DATA_W),
        .STAGES (STAGES)
    ) u_stages (
        .operand (operand),
        .kind    (shift_kind),
        .amt_low (amt_low),
        .shifted (shifted),
        .norm    (norm)
    );

    shf_carry_pick #(
        .DATA_W (DATA_W),
        .STAGES (STAGES)
    ) u_carry (
        .norm      (norm),
        .sign_bit  (operand[DATA_W-1]),
        .kind      (shift_kind),
        .amt_low   (amt_low),
        .amt_class (amt_class),
        .carry_in  (carry_in),
        .carry     (carry_sel)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.carry = carry_sel;
            if (shift_kind == SK_RSV) begin
                state_d.data = operand;
            end else begin
                unique case (amt_class)
                    AC_ZERO:  state_d.data = operand;
                    AC_RANGE: state_d.data = shifted;
                    default:  state_d.data = (shift_kind == SK_ASR) ?
                                             {DATA_W{operand[DATA_W-1]}} : '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.data;
    assign carry_out = state_q.carry;

endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 32,
    parameter int USED_W = 8,
    parameter int IMM_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] operand,
    input logic [AMT_W-1:0]  amount_reg,
    input logic [1:0]        shift_kind,
    input logic              carry_in,
    input logic              imm_mode,
    input logic [IMM_W-1:0]  imm_amount,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              carry_out
);

    logic [USED_W-1:0] low_amt;
    logic              rst_seen;

    assign low_amt = amount_reg[USED_W-1:0];

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen) begin
            AST_RESET_CLEARS: assert (!out_valid && result == '0 && !carry_out); // R11
        end
    end

    AST_HIGH_BITS_IGNORED: assert property (@(posedge clk) disable iff (rst)
        in_valid && !imm_mode && shift_kind != 2'b11 && low_amt == '0 &&
        amount_reg[AMT_W-1:USED_W] != '0
        |=> result == $past(operand) && carry_out == $past(carry_in)); // R1

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid && !imm_mode && low_amt == '0
        |=> result == $past(operand) && carry_out == $past(carry_in)); // R2

    AST_LSL_FULL: assert property (@(posedge clk) disable iff (rst)
        in_valid && !imm_mode && shift_kind == 2'b00 && low_amt == USED_W'(DATA_W)
        |=> result == '0 && carry_out == $past(operand[0])); // R4

    AST_LSR_FULL: assert property (@(posedge clk) disable iff (rst)
        in_valid && !imm_mode && shift_kind == 2'b01 && low_amt == USED_W'(DATA_W)
        |=> result == '0 && carry_out == $past(operand[DATA_W-1])); // R5

    AST_LOGIC_BEYOND: assert property (@(posedge clk) disable iff (rst)
        in_valid && !imm_mode && (shift_kind == 2'b00 || shift_kind == 2'b01) &&
        low_amt > USED_W'(DATA_W)
        |=> result == '0 && !carry_out); // R6

    AST_ASR_WIDE: assert property (@(posedge clk) disable iff (rst)
        in_valid && !imm_mode && shift_kind == 2'b10 && low_amt >= USED_W'(DATA_W)
        |=> result == {DATA_W{$past(operand[DATA_W-1])}} &&
            carry_out == $past(operand[DATA_W-1])); // R7

    AST_IMM_ZERO_RIGHT: assert property (@(posedge clk) disable iff (rst)
        in_valid && imm_mode && imm_amount == '0 && shift_kind == 2'b01
        |=> result == '0 && carry_out == $past(operand[DATA_W-1])); // R8

    AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid && shift_kind == 2'b11
        |=> result == $past(operand) && carry_out == $past(carry_in)); // R9

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(result) && $stable(carry_out)); // R10

endmodule

bind barrel_shift_carry shf_checker #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W),
    .USED_W (USED_W),
    .IMM_W  (IMM_W)
) u_chk (.*);

// File: tb/barrel_shift_carry_tb.sv
module barrel_shift_carry_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [31:0] amount_reg = '0;
    logic [1:0]  shift_kind = '0;
    logic        carry_in = 1'b0;
    logic        imm_mode = 1'b0;
    logic [4:0]  imm_amount = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    bit    model_live = 0;
    string cur_tag = "R11";
    string exp_tag = "R11";
    logic        exp_v = 1'b0;
    logic [31:0] exp_r = '0;
    logic        exp_c = 1'b0;

    always #5 clk = ~clk;

    barrel_shift_carry u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .operand    (operand),
        .amount_reg (amount_reg),
        .shift_kind (shift_kind),
        .carry_in   (carry_in),
        .imm_mode   (imm_mode),
        .imm_amount (imm_amount),
        .out_valid  (out_valid),
        .result     (result),
        .carry_out  (carry_out)
    );

    // Behavioural reference: returns {carry, result}.
    function automatic logic [32:0] ref_op(input logic [31:0] op, input logic [31:0] amt,
                                           input logic [1:0] kind, input logic cin,
                                           input logic imm, input logic [4:0] ia);
        int n;
        logic [31:0] r;
        logic c;
        if (imm) n = (ia == 0 && (kind == 2'b01 || kind == 2'b10)) ? 32 : int'(ia);
        else     n = int'(amt[7:0]);
        if (kind == 2'b11 || n == 0) begin
            r = op; c = cin;
        end else if (kind == 2'b00) begin
            if (n < 32)       begin r = op << n; c = op[32-n]; end
            else if (n == 32) begin r = 0; c = op[0]; end
            else              begin r = 0; c = 0; end
        end else if (kind == 2'b01) begin
            if (n < 32)       begin r = op >> n; c = op[n-1]; end
            else if (n == 32) begin r = 0; c = op[31]; end
            else              begin r = 0; c = 0; end
        end else begin
            if (n < 32) begin r = 32'($signed(op) >>> n); c = op[n-1]; end
            else        begin r = {32{op[31]}}; c = op[31]; end
        end
        return {c, r};
    endfunction

    always @(posedge clk) begin
        logic [32:0] m;
        m = ref_op(operand, amount_reg, shift_kind, carry_in, imm_mode, imm_amount);
        if (rst) begin
            exp_v <= 1'b0; exp_r <= '0; exp_c <= 1'b0;
        end else if (in_valid) begin
            exp_v <= 1'b1; exp_r <= m[31:0]; exp_c <= m[32];
        end else begin
            exp_v <= 1'b0;
        end
        exp_tag    <= cur_tag;
        model_live <= 1'b1;
    end

    always @(posedge clk) begin
        #2;
        if (model_live && !finished) begin
            checks++;
            if (out_valid !== exp_v || result !== exp_r || carry_out !== exp_c) begin
                failures++;
                $display("FAIL %s: valid=%b result=%h carry=%b expected valid=%b result=%h carry=%b",
                         exp_tag, out_valid, result, carry_out, exp_v, exp_r, exp_c);
            end
        end
    end

    task automatic op_reg(input logic [31:0] op, input logic [31:0] amt, input logic [1:0] kind,
                          input logic cin, input string tag);
        @(negedge clk);
        in_valid = 1'b1; operand = op; amount_reg = amt; shift_kind = kind;
        carry_in = cin; imm_mode = 1'b0; imm_amount = 5'($urandom);
        cur_tag = tag;
    endtask

    task automatic op_imm(input logic [31:0] op, input logic [4:0] ia, input logic [1:0] kind,
                          input logic cin, input string tag);
        @(negedge clk);
        in_valid = 1'b1; operand = op; amount_reg = $urandom; shift_kind = kind;
        carry_in = cin; imm_mode = 1'b1; imm_amount = ia;
        cur_tag = tag;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0; operand = $urandom; amount_reg = $urandom;
            shift_kind = 2'($urandom); carry_in = 1'($urandom);
            imm_mode = 1'($urandom); imm_amount = 5'($urandom);
            cur_tag = "R10";
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cur_tag = "R2";
        // R2: zero amount, all kinds, both carry values
        for (int k = 0; k < 3; k++) begin
            op_reg(32'hFFFF_FFFE, 32'h0, 2'(k), 1'b1, "R2");
            op_reg(32'h8000_0001, 32'h0, 2'(k), 1'b0, "R2");
        end
        // R1: only the low byte counts
        for (int k = 0; k < 3; k++) op_reg(32'hFFFF_FFFE, 32'h100, 2'(k), 1'b1, "R1");
        op_reg(32'h1234_5678, 32'hABCD_EF04, 2'b00, 1'b0, "R1");
        op_reg(32'h8765_4321, 32'h7777_7703, 2'b10, 1'b0, "R1");
        // R3: in-range amounts
        op_reg(32'h8000_0001, 32'd1, 2'b00, 1'b0, "R3");
        op_reg(32'h8000_0001, 32'd1, 2'b01, 1'b0, "R3");
        op_reg(32'h8000_0001, 32'd1, 2'b10, 1'b0, "R3");
        op_reg(32'hC000_0003, 32'd31, 2'b00, 1'b0, "R3");
        op_reg(32'hC000_0003, 32'd31, 2'b01, 1'b0, "R3");
        op_reg(32'hC000_0003, 32'd31, 2'b10, 1'b0, "R3");
        op_reg(32'hDEAD_BEEF, 32'd13, 2'b10, 1'b1, "R3");
        // R4 / R5: exactly 32
        op_reg(32'hFFFF_FFFF, 32'd32, 2'b00, 1'b0, "R4");
        op_reg(32'h7FFF_FFFE, 32'd32, 2'b00, 1'b1, "R4");
        op_reg(32'hFFFF_FFFF, 32'd32, 2'b01, 1'b0, "R5");
        op_reg(32'h7FFF_FFFF, 32'd32, 2'b01, 1'b1, "R5");
        // R6: 33 and 255, logical
        op_reg(32'hFFFF_FFFF, 32'd33, 2'b00, 1'b1, "R6");
        op_reg(32'hFFFF_FFFF, 32'd33, 2'b01, 1'b1, "R6");
        op_reg(32'hFFFF_FFFF, 32'd255, 2'b00, 1'b1, "R6");
        op_reg(32'hFFFF_FFFF, 32'hFF, 2'b01, 1'b1, "R6");
        // R7: arithmetic wide
        op_reg(32'hFFFF_FFFF, 32'd32, 2'b10, 1'b0, "R7");
        op_reg(32'hFFFF_FFFF, 32'd33, 2'b10, 1'b0, "R7");
        op_reg(32'h7FFF_FFFF, 32'd200, 2'b10, 1'b1, "R7");
        // R8: immediate mode
        op_imm(32'hFFFF_FFFF, 5'd0, 2'b01, 1'b0, "R8");
        op_imm(32'hFFFF_FFFF, 5'd0, 2'b10, 1'b0, "R8");
        op_imm(32'h7FFF_FFFF, 5'd0, 2'b10, 1'b1, "R8");
        op_imm(32'hFFFF_FFFE, 5'd0, 2'b00, 1'b1, "R8");
        op_imm(32'h8000_0001, 5'd31, 2'b00, 1'b0, "R8");
        op_imm(32'hF0F0_1234, 5'd7, 2'b01, 1'b1, "R8");
        // R9: reserved kind
        op_reg(32'hCAFE_F00D, 32'd5, 2'b11, 1'b1, "R9");
        op_imm(32'h1357_9BDF, 5'd0, 2'b11, 1'b0, "R9");
        // R10: hold while idle
        idle(4);
        op_reg(32'h0000_00F0, 32'd4, 2'b01, 1'b1, "R10");
        idle(3);
        // R11: reset mid-run
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1; cur_tag = "R11";
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            int pick;
            pick = int'($urandom_range(0, 5));
            a = $urandom;
            if (pick == 0) a[7:0] = 8'd0;
            else if (pick == 1) a[7:0] = 8'd32;
            else if (pick == 2) a[7:0] = 8'd33;
            else if (pick == 3) a[7:0] = 8'($urandom_range(1, 31));
            if ($urandom_range(0, 3) == 0) op_imm($urandom, 5'($urandom), 2'($urandom), 1'($urandom), "R3");
            else op_reg($urandom, a, 2'($urandom), 1'($urandom), "R3");
            if ($urandom_range(0, 7) == 0) idle(1);
        end
        idle(2);
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule